// File: doc/BRIEF.md
# USB device interrupt mask and status register

This block holds the control byte and the sticky interrupt status byte of a USB device controller. Software reaches both through a simple synchronous register bus: an address, a write strobe, write data and a combinational read-data path. The control byte carries a device enable bit, a read-only activity flag and five interrupt mask bits. The masks cover endpoint zero, receive, transmit, suspend/resume and bus reset.

Event pulses arrive one cycle wide from the controller core. An event records itself in its sticky status bit only while its mask is clear. A mask does not gate the interrupt line. It only prevents a status bit from rising, so a bit that is already set stays set when its mask is later raised. Software clears status bits by writing ones to the status address. A single interrupt request output is high while any status bit is set.

Top module: `usbd_irq_regs`

## Requirements
- R1: After reset the control byte reads 0xF8 (enable 0, activity 0, all five masks 1), the status byte reads 0x00 and `irq` is 0.
- R2: The control byte is at address 0. Bit 0 is the device enable and drives `dev_en`. Bits 3 to 7 are the masks for endpoint zero, receive, transmit, suspend/resume and bus reset, in that order, with 1 meaning masked. Written values read back. Other addresses than 0 and 1 read 0 and ignore writes.
- R3: Control bit 2 is reserved: writes are ignored and it reads 0. Control bit 1 is read-only and reads `link_ok` AND the enable bit, whatever value is written to it.
- R4: The status byte is at address 1. Bit 0 is endpoint zero, bit 1 receive, bit 2 transmit, bit 3 suspend, bit 4 resume and bit 5 bus reset, matching `ev` bits 0 to 5. Bits 6 and 7 read 0. An event pulse whose mask is 0 sets its bit at the clock edge where it is sampled.
- R5: An event whose mask is 1 at the sampling edge does not set its bit. The suspend/resume mask blocks both bit 3 and bit 4.
- R6: Writing a mask to 1 leaves status bits that are already set unchanged.
- R7: Writing to the status address clears each bit written with 1. Bits written with 0 are unchanged.
- R8: If a clearing write and an unmasked event for the same bit fall in the same cycle, the bit ends set.
- R9: `irq` is 1 exactly when at least one status bit is set, whatever the mask values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ev | input | 6 | Single-cycle event pulses, bit order as the status byte |
| link_ok | input | 1 | High while the device is neither suspended nor held in bus reset |
| dev_en | output | 1 | Device enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: a 4-bit address with the control byte at 0 and the status byte at 1. This leaves free addresses that show how unmapped accesses behave. With these defaults, all six event sources and all five masks can be driven directly. That lets the bench pair each mask with its own events and cross them, including the shared suspend/resume mask and a clear that lands in the same cycle as an event.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_EV  = 6;
    localparam int NUM_MSK = 5;

    // control byte field positions
    localparam int C_EN    = 0;
    localparam int C_ACT   = 1;
    localparam int C_RSVD  = 2;
    localparam int C_MSK0  = 3;

    // event/status index order
    typedef enum logic [2:0] {
        EV_EP0   = 3'd0,
        EV_RX    = 3'd1,
        EV_TX    = 3'd2,
        EV_SUSP  = 3'd3,
        EV_RESM  = 3'd4,
        EV_BRST  = 3'd5
    } ev_id_t;

    // which mask guards each event
    function automatic int mask_of(input int ev_idx);
        case (ev_idx)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3, 4:    return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/usbd_ctrl_reg.sv
module usbd_ctrl_reg
    import usbd_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              en_o,
    output logic [NUM_MSK-1:0] mask_o
);
    logic               en_q;
    logic [NUM_MSK-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= '1;
        end else if (wr_i) begin
            en_q   <= wdata_i[C_EN];
            mask_q <= wdata_i[C_MSK0 +: NUM_MSK];
        end
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;

    // R2: a control write lands in the enable and mask fields
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_q == $past(wdata_i[C_EN])) &&
                 (mask_q == $past(wdata_i[C_MSK0 +: NUM_MSK])));

    // R2: without a write the fields hold
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_q) && $stable(mask_q));
endmodule

// File: rtl/usbd_stat_bit.sv
module usbd_stat_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic mask_i,
    input  logic clr_i,
    output logic bit_o
);
    logic bit_q;
    logic set_ok;

    assign set_ok = ev_i && !mask_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_q <= 1'b0;
        else if (set_ok)
            bit_q <= 1'b1;
        else if (clr_i)
            bit_q <= 1'b0;
    end

    assign bit_o = bit_q;

    // R5: a masked event cannot raise a clear bit
    a_r5_masked_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_q && (!ev_i || mask_i)) |=> !bit_q);

    // R4 / R8: an unmasked event always leaves the bit set, even against a clear
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !mask_i) |=> bit_q);

    // R6: without a clear a set bit stays set, whatever the mask does
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !clr_i) |=> bit_q);

    // R7: a clear with no competing event drops the bit
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(ev_i && !mask_i)) |=> !bit_q);
endmodule

// File: rtl/usbd_rd_mux.sv
module usbd_rd_mux
    import usbd_irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               en_i,
    input  logic               link_ok_i,
    input  logic [NUM_MSK-1:0] mask_i,
    input  logic [NUM_EV-1:0]  stat_i,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL) begin
            rdata_o[C_EN]                = en_i;
            rdata_o[C_ACT]               = en_i && link_ok_i;
            rdata_o[C_RSVD]              = 1'b0;
            rdata_o[C_MSK0 +: NUM_MSK]   = mask_i;
        end else if (addr_i == A_STAT) begin
            rdata_o[NUM_EV-1:0]          = stat_i;
        end
    end
endmodule

// File: rtl/usbd_irq_regs.sv
module usbd_irq_regs
    import usbd_irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [5:0]        ev,
    input  logic              link_ok,
    output logic              dev_en,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic               ctrl_wr;
    logic               stat_wr;
    logic               en;
    logic [NUM_MSK-1:0] mask;
    logic [NUM_EV-1:0]  stat;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign stat_wr = bus_wr && (bus_addr == A_STAT);

    usbd_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr),
        .wdata_i (bus_wdata),
        .en_o    (en),
        .mask_o  (mask)
    );

    for (genvar i = 0; i < NUM_EV; i++) begin : g_stat
        usbd_stat_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev_i   (ev[i]),
            .mask_i (mask[mask_of(i)]),
            .clr_i  (stat_wr && bus_wdata[i]),
            .bit_o  (stat[i])
        );
    end

    usbd_rd_mux #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_rd (
        .addr_i    (bus_addr),
        .en_i      (en),
        .link_ok_i (link_ok),
        .mask_i    (mask),
        .stat_i    (stat),
        .rdata_o   (bus_rdata)
    );

    assign dev_en = en;
    assign irq    = |stat;

    // R9: the request line drops only after a status write
    a_r9_irq_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_wr));

    // R3: reserved control bit never reads as 1
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> !bus_rdata[C_RSVD]);
endmodule

// File: tb/tb_usbd_irq_regs.sv
module tb_usbd_irq_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] ev = '0;
    logic       link_ok = 1'b0;
    logic       dev_en;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    usbd_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev(ev),
        .link_ok(link_ok), .dev_en(dev_en), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk);
        ev = e;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(4'd0, d); check("R1 ctrl", d, 8'hF8);
        rd(4'd1, d); check("R1 status", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] d;
        wr(4'd0, 8'hA9);                 // enable, masks 1,0,1,0,1
        rd(4'd0, d); check("R2 readback", d, 8'hA9);
        check("R2 dev_en", {7'd0, dev_en}, 8'h01);
        wr(4'd5, 8'h00);                 // unmapped
        rd(4'd0, d); check("R2 unmapped write ignored", d, 8'hA9);
        rd(4'd5, d); check("R2 unmapped read", d, 8'h00);
        wr(4'd0, 8'hF8);
        check("R2 dev_en low", {7'd0, dev_en}, 8'h00);
    endtask

    task automatic t_ro_fields();
        logic [7:0] d;
        link_ok = 1'b1;
        wr(4'd0, 8'hFE);                 // enable 0, tries bits 1 and 2
        rd(4'd0, d); check("R3 act needs enable, rsvd 0", d, 8'hF8);
        wr(4'd0, 8'hFD);                 // enable 1, bit1 0, bit2 1
        rd(4'd0, d); check("R3 act follows link_ok", d, 8'hFB);
        link_ok = 1'b0;
        rd(4'd0, d); check("R3 act drops with link_ok", d, 8'hF9);
    endtask

    task automatic t_unmasked();
        logic [7:0] d;
        wr(4'd0, 8'h01);                 // all masks clear
        pulse(6'b000101);
        rd(4'd1, d); check("R4 ep0 and tx set", d, 8'h05);
        check("R9 irq high", {7'd0, irq}, 8'h01);
        pulse(6'b111010);
        rd(4'd1, d); check("R4 all bits set", d, 8'h3F);
        wr(4'd1, 8'hFF);
        rd(4'd1, d); check("R7 clear all", d, 8'h00);
        check("R9 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_masked();
        logic [7:0] d;
        wr(4'd0, 8'h41);                 // only suspend/resume masked
        pulse(6'b011000);
        rd(4'd1, d); check("R5 susres mask blocks both", d, 8'h00);
        pulse(6'b100000);
        rd(4'd1, d); check("R5 reset unmasked sets", d, 8'h20);
        wr(4'd1, 8'h20);
        wr(4'd0, 8'h81);                 // only bus reset masked
        pulse(6'b110000);
        rd(4'd1, d); check("R5 reset mask blocks", d, 8'h10);
        wr(4'd1, 8'h10);
        wr(4'd0, 8'h39);                 // ep0, rx, tx masked
        pulse(6'b000111);
        rd(4'd1, d); check("R5 ep0/rx/tx masked", d, 8'h00);
    endtask

    task automatic t_mask_keeps();
        logic [7:0] d;
        wr(4'd0, 8'h01);
        pulse(6'b001010);
        wr(4'd0, 8'hF9);                 // mask everything
        rd(4'd1, d); check("R6 set bits kept", d, 8'h0A);
        check("R9 irq independent of masks", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        wr(4'd1, 8'h00);
        rd(4'd1, d); check("R7 zero write no effect", d, 8'h0A);
        wr(4'd1, 8'h02);
        rd(4'd1, d); check("R7 partial clear", d, 8'h08);
        wr(4'd1, 8'h08);
        rd(4'd1, d); check("R7 last clear", d, 8'h00);
        check("R9 irq low after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        wr(4'd0, 8'h01);
        pulse(6'b000001);
        @(negedge clk);
        bus_addr = 4'd1; bus_wdata = 8'h03; bus_wr = 1'b1; ev = 6'b000010;
        @(negedge clk);
        bus_wr = 1'b0; ev = '0;
        rd(4'd1, d); check("R8 event beats clear", d, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_rw();
        t_ro_fields();
        t_unmasked();
        t_masked();
        t_mask_keeps();
        t_w1c();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #40000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule